// File: doc/BRIEF.md
# Nested Transaction Tracking Controller

This block follows hardware memory transactions for a single core that sits on a small data cache. A command input opens a transaction, closes one nesting level, or abandons the transaction on request. Access notifications name a cache line index and say whether the access reads or writes. While a transaction is open, every touched line gets a read marker or a write marker in a per-line array. Markers are kept at whole-line granularity, and a line is 64 bytes. Nesting is flattened: one depth counter with a hard ceiling. Only the outermost close commits.

A commit publishes all speculative written lines in one step. It clears every marker on the same clock edge, and a one-cycle publish vector names the lines. An abort discards speculative data. A one-cycle flush vector names every line that held a write marker, so the cache can invalidate those lines.

Several conditions force an abort:
- a conflict reported on the snoop input,
- eviction of a written line, since the next cache level keeps no transactional state,
- an open command beyond the depth ceiling,
- an explicit abort command.

When a line that is only read gets evicted, the transaction survives. The line moves into a small overflow signature that is indexed by the low bits of the line number, and snoops keep checking against that signature. Register rollback and the coherence protocol belong to other blocks.

Top module: `txn_tracker`

## Requirements
- R1: After synchronous reset the depth is 0, all read markers, write markers and signature bits are 0, the done, committed and aborted pulses are low, the flush and publish vectors are 0 and the cause is 0.
- R2: The command encoding is 0 = none, 1 = open, 2 = close, 3 = abort. An open command adds one to the depth. An open command received while the depth equals MAX_DEPTH (7 by default) aborts the whole transaction with cause 4 (nesting overflow).
- R3: A close command at a depth above 1 only lowers the depth by one. A close at depth 1 commits: one cycle later committed and done pulse, publish_lines equals the write markers from before the commit, and all state is 0. A close at depth 0 has no effect.
- R4: While the depth is non-zero, a read access sets the line's read marker and a write access sets its write marker. Accesses, evictions, snoops and abort commands at depth 0 change nothing.
- R5: Eviction of a line that holds a write marker, while a transaction is open, aborts with cause 3 (capacity).
- R6: Eviction of a line that holds only a read marker clears that marker and sets signature bit (line mod SIG_BITS), without an abort. If an access hits the same line in the same cycle, the access is applied after the eviction.
- R7: A snoop whose line has a read marker or a write marker, or whose signature bit (line mod SIG_BITS) is set, aborts with cause 2 (conflict) while a transaction is open.
- R8: An abort command while a transaction is open aborts with cause 1 (explicit).
- R9: On any abort, one cycle later aborted and done pulse for one cycle, flush_lines equals the write markers from before the abort, and depth, markers and signature are all 0.
- R10: When several abort reasons occur in the same cycle, the cause is the first that applies in the order explicit, conflict, capacity, nesting. An abort takes precedence over a commit in the same cycle.
- R11: The cause output holds its value until the next outermost open command, which sets it back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command: 0 none, 1 open, 2 close, 3 abort |
| acc_valid | input | 1 | Access notification valid |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_line | input | IW | Cache line index of the access |
| evict_valid | input | 1 | Cache evicts a line this cycle |
| evict_line | input | IW | Index of the evicted line |
| snoop_valid | input | 1 | External access that may conflict |
| snoop_line | input | IW | Line index of the external access |
| txn_depth | output | DW | Current nesting depth |
| txn_active | output | 1 | Depth is non-zero |
| rd_marks | output | NUM_LINES | Read markers per line |
| wr_marks | output | NUM_LINES | Write markers per line |
| ovf_sig | output | SIG_BITS | Overflow signature of evicted read lines |
| done | output | 1 | One-cycle pulse after commit or abort |
| committed | output | 1 | One-cycle pulse after commit |
| aborted | output | 1 | One-cycle pulse after abort |
| abort_cause | output | 3 | Cause of the last abort, 0 when cleared |
| flush_lines | output | NUM_LINES | One-cycle vector of lines to invalidate |
| publish_lines | output | NUM_LINES | One-cycle vector of lines made visible |

## Verification
Every result is registered, so each result appears on the first rising edge after the stimulus is sampled. This covers marker updates, depth changes, the signature bit, the cause code and the done, commit, abort, flush and publish pulses. The bench drives inputs on the falling edge and updates its model for that same rising edge. It compares every output on the next falling edge, so each check covers exactly one edge. The pulses are also checked to be low on the cycle after they fire, and a held cause is checked over several idle cycles.

// File: rtl/txn_pkg.sv
package txn_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_BEGIN = 2'd1,
        OP_END   = 2'd2,
        OP_ABORT = 2'd3
    } txn_op_e;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_EXPLICIT = 3'd1,
        CAUSE_CONFLICT = 3'd2,
        CAUSE_CAPACITY = 3'd3,
        CAUSE_NEST     = 3'd4
    } abort_cause_e;

    typedef struct packed {
        logic explicit_req;
        logic conflict;
        logic capacity;
        logic nest;
    } abort_req_t;

    function automatic logic any_abort(abort_req_t r);
        return r.explicit_req | r.conflict | r.capacity | r.nest;
    endfunction

    // Fixed priority: explicit, conflict, capacity, nesting.
    function automatic abort_cause_e pick_cause(abort_req_t r);
        if (r.explicit_req) return CAUSE_EXPLICIT;
        if (r.conflict)     return CAUSE_CONFLICT;
        if (r.capacity)     return CAUSE_CAPACITY;
        if (r.nest)         return CAUSE_NEST;
        return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/txn_depth.sv
module txn_depth
    import txn_pkg::*;
#(
    parameter int MAX_DEPTH = 7,
    parameter int DW        = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  txn_op_e       op,
    input  logic          kill,
    output logic [DW-1:0] depth,
    output logic          active,
    output logic          nest_ovf,
    output logic          outer_end
);

    always_comb begin
        active    = (depth != '0);
        nest_ovf  = active && (op == OP_BEGIN) && (depth == DW'(MAX_DEPTH));
        outer_end = (op == OP_END) && (depth == DW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else if (kill) begin
            depth <= '0;
        end else if (op == OP_BEGIN && !nest_ovf) begin
            depth <= depth + DW'(1);
        end else if (op == OP_END && depth > DW'(1)) begin
            depth <= depth - DW'(1);
        end
    end

    // R2: the counter never passes its ceiling
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        depth <= DW'(MAX_DEPTH));

    // R3: an inner close only steps the depth down by one
    a_r3_inner_end: assert property (@(posedge clk) disable iff (rst)
        (op == OP_END && depth > DW'(1) && !kill) |=> (depth == $past(depth) - DW'(1)));

endmodule

// File: rtl/txn_line_sets.sv
module txn_line_sets #(
    parameter int NUM_LINES = 64,
    parameter int IW        = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic                 clear,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [IW-1:0]        acc_line,
    input  logic                 evict_valid,
    input  logic [IW-1:0]        evict_line,
    input  logic [IW-1:0]        snoop_line,
    output logic [NUM_LINES-1:0] rd_marks,
    output logic [NUM_LINES-1:0] wr_marks,
    output logic                 evict_wr_hit,
    output logic                 evict_rd_only,
    output logic                 snoop_hit
);

    always_comb begin
        evict_wr_hit  = active && evict_valid && wr_marks[evict_line];
        evict_rd_only = active && evict_valid && rd_marks[evict_line] && !wr_marks[evict_line];
        snoop_hit     = rd_marks[snoop_line] || wr_marks[snoop_line];
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic acc_here;
        logic evict_here;

        always_comb begin
            acc_here   = active && acc_valid   && (acc_line   == IW'(i));
            evict_here = active && evict_valid && (evict_line == IW'(i));
        end

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                rd_marks[i] <= 1'b0;
                wr_marks[i] <= 1'b0;
            end else begin
                // eviction first, then the access lands in the cache again
                if (acc_here && !acc_write) begin
                    rd_marks[i] <= 1'b1;
                end else if (evict_here) begin
                    rd_marks[i] <= 1'b0;
                end
                if (acc_here && acc_write) begin
                    wr_marks[i] <= 1'b1;
                end
            end
        end
    end

    // R4: no markers exist outside a transaction
    a_r4_idle_empty: assert property (@(posedge clk) disable iff (rst)
        !active |-> (rd_marks == '0 && wr_marks == '0));

endmodule

// File: rtl/txn_ovf_sig.sv
module txn_ovf_sig #(
    parameter int SIG_BITS = 16,
    parameter int SW       = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                set_en,
    input  logic [SW-1:0]       set_slot,
    input  logic [SW-1:0]       probe_slot,
    output logic [SIG_BITS-1:0] sig,
    output logic                probe_hit
);

    always_comb probe_hit = sig[probe_slot];

    for (genvar b = 0; b < SIG_BITS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                sig[b] <= 1'b0;
            end else if (set_en && set_slot == SW'(b)) begin
                sig[b] <= 1'b1;
            end
        end
    end

    // R6: a signature bit only appears after a read-only eviction
    a_r6_sig_source: assert property (@(posedge clk) disable iff (rst)
        (sig != $past(sig) && !$past(clear)) |-> $past(set_en));

endmodule

// File: rtl/txn_tracker.sv
module txn_tracker
    import txn_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int SIG_BITS  = 16,
    parameter int MAX_DEPTH = 7,
    localparam int IW = $clog2(NUM_LINES),
    localparam int DW = $clog2(MAX_DEPTH + 1),
    localparam int SW = (SIG_BITS > 1) ? $clog2(SIG_BITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cmd_op,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [IW-1:0]        acc_line,
    input  logic                 evict_valid,
    input  logic [IW-1:0]        evict_line,
    input  logic                 snoop_valid,
    input  logic [IW-1:0]        snoop_line,
    output logic [DW-1:0]        txn_depth,
    output logic                 txn_active,
    output logic [NUM_LINES-1:0] rd_marks,
    output logic [NUM_LINES-1:0] wr_marks,
    output logic [SIG_BITS-1:0]  ovf_sig,
    output logic                 done,
    output logic                 committed,
    output logic                 aborted,
    output logic [2:0]           abort_cause,
    output logic [NUM_LINES-1:0] flush_lines,
    output logic [NUM_LINES-1:0] publish_lines
);

    txn_op_e      op;
    abort_req_t   req;
    abort_cause_e cause_q;
    logic         nest_ovf, outer_end;
    logic         evict_wr_hit, evict_rd_only, snoop_hit, sig_hit;
    logic         do_abort, do_commit, kill;

    always_comb op = txn_op_e'(cmd_op);

    txn_depth #(.MAX_DEPTH(MAX_DEPTH), .DW(DW)) u_depth (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .kill      (kill),
        .depth     (txn_depth),
        .active    (txn_active),
        .nest_ovf  (nest_ovf),
        .outer_end (outer_end)
    );

    txn_line_sets #(.NUM_LINES(NUM_LINES), .IW(IW)) u_sets (
        .clk           (clk),
        .rst           (rst),
        .active        (txn_active),
        .clear         (kill),
        .acc_valid     (acc_valid),
        .acc_write     (acc_write),
        .acc_line      (acc_line),
        .evict_valid   (evict_valid),
        .evict_line    (evict_line),
        .snoop_line    (snoop_line),
        .rd_marks      (rd_marks),
        .wr_marks      (wr_marks),
        .evict_wr_hit  (evict_wr_hit),
        .evict_rd_only (evict_rd_only),
        .snoop_hit     (snoop_hit)
    );

    txn_ovf_sig #(.SIG_BITS(SIG_BITS), .SW(SW)) u_sig (
        .clk        (clk),
        .rst        (rst),
        .clear      (kill),
        .set_en     (evict_rd_only),
        .set_slot   (evict_line[SW-1:0]),
        .probe_slot (snoop_line[SW-1:0]),
        .sig        (ovf_sig),
        .probe_hit  (sig_hit)
    );

    always_comb begin
        req.explicit_req = txn_active && (op == OP_ABORT);
        req.conflict     = txn_active && snoop_valid && (snoop_hit || sig_hit);
        req.capacity     = evict_wr_hit;
        req.nest         = nest_ovf;
        do_abort         = any_abort(req);
        do_commit        = outer_end && !do_abort;
        kill             = do_abort || do_commit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done          <= 1'b0;
            committed     <= 1'b0;
            aborted       <= 1'b0;
            cause_q       <= CAUSE_NONE;
            flush_lines   <= '0;
            publish_lines <= '0;
        end else begin
            done          <= kill;
            committed     <= do_commit;
            aborted       <= do_abort;
            flush_lines   <= do_abort  ? wr_marks : '0;
            publish_lines <= do_commit ? wr_marks : '0;
            if (do_abort) begin
                cause_q <= pick_cause(req);
            end else if (op == OP_BEGIN && !txn_active) begin
                cause_q <= CAUSE_NONE;
            end
        end
    end

    always_comb abort_cause = cause_q;

    // R9: everything is cleared when done fires
    a_r9_clear_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (txn_depth == '0 && rd_marks == '0 && wr_marks == '0 && ovf_sig == '0));

    // R10: commit and abort never fire together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(committed && aborted));

    // R3: a commit only follows depth 1
    a_r3_commit_depth: assert property (@(posedge clk) disable iff (rst)
        committed |-> ($past(txn_depth) == DW'(1)));

    // R5: evicting a written line always aborts
    a_r5_capacity: assert property (@(posedge clk) disable iff (rst)
        (txn_active && evict_valid && wr_marks[evict_line]) |=> aborted);

    // R9: done accompanies every commit or abort
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done == (committed || aborted));

endmodule

// File: tb/test_txn_tracker.sv
module test_txn_tracker;

    localparam int NL = 16;
    localparam int SB = 4;
    localparam int MD = 7;
    localparam int IW = 4;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    cmd_op;
    logic          acc_valid, acc_write, evict_valid, snoop_valid;
    logic [IW-1:0] acc_line, evict_line, snoop_line;
    logic [DW-1:0] txn_depth;
    logic          txn_active, done, committed, aborted;
    logic [NL-1:0] rd_marks, wr_marks, flush_lines, publish_lines;
    logic [SB-1:0] ovf_sig;
    logic [2:0]    abort_cause;

    always #10 clk = ~clk;

    txn_tracker #(.NUM_LINES(NL), .SIG_BITS(SB), .MAX_DEPTH(MD)) i_txn_tracker (
        .clk(clk), .rst(rst), .cmd_op(cmd_op),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_line(acc_line),
        .evict_valid(evict_valid), .evict_line(evict_line),
        .snoop_valid(snoop_valid), .snoop_line(snoop_line),
        .txn_depth(txn_depth), .txn_active(txn_active),
        .rd_marks(rd_marks), .wr_marks(wr_marks), .ovf_sig(ovf_sig),
        .done(done), .committed(committed), .aborted(aborted),
        .abort_cause(abort_cause), .flush_lines(flush_lines),
        .publish_lines(publish_lines)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // reference model state
    logic [NL-1:0] m_rd, m_wr, m_flush, m_pub;
    logic [SB-1:0] m_sig;
    int            m_depth, m_cause;
    bit            m_done, m_ab, m_cm;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(int'(txn_depth) == m_depth, tag, "depth", longint'(txn_depth), longint'(m_depth));
        chk(txn_active == (m_depth != 0), tag, "active", longint'(txn_active), longint'(m_depth != 0));
        chk(rd_marks == m_rd, tag, "rd_marks", longint'(rd_marks), longint'(m_rd));
        chk(wr_marks == m_wr, tag, "wr_marks", longint'(wr_marks), longint'(m_wr));
        chk(ovf_sig == m_sig, tag, "ovf_sig", longint'(ovf_sig), longint'(m_sig));
        chk(done == m_done && committed == m_cm && aborted == m_ab, tag, "pulses",
            longint'({done, committed, aborted}), longint'({m_done, m_cm, m_ab}));
        chk(int'(abort_cause) == m_cause, tag, "cause", longint'(abort_cause), longint'(m_cause));
        chk(flush_lines == m_flush, tag, "flush", longint'(flush_lines), longint'(m_flush));
        chk(publish_lines == m_pub, tag, "publish", longint'(publish_lines), longint'(m_pub));
    endtask

    task automatic model_step(input int op, input bit av, input bit aw, input int al,
                              input bit ev, input int el, input bit sv, input int sl);
        bit act, ex, cf, cap, ns, ab, cm;
        act = (m_depth != 0);
        ex  = act && op == 3;
        cf  = act && sv && (m_rd[sl] || m_wr[sl] || m_sig[sl % SB]);
        cap = act && ev && m_wr[el];
        ns  = act && op == 1 && m_depth == MD;
        ab  = ex || cf || cap || ns;
        cm  = !ab && act && op == 2 && m_depth == 1;
        m_flush = ab ? m_wr : '0;
        m_pub   = cm ? m_wr : '0;
        m_ab = ab; m_cm = cm; m_done = ab || cm;
        if (ab) m_cause = ex ? 1 : cf ? 2 : cap ? 3 : 4;
        else if (op == 1 && !act) m_cause = 0;
        if (ab || cm) begin
            m_depth = 0; m_rd = '0; m_wr = '0; m_sig = '0;
        end else begin
            if (op == 1) m_depth++;
            else if (op == 2 && m_depth > 1) m_depth--;
            if (act && ev && m_rd[el] && !m_wr[el]) begin
                m_rd[el] = 1'b0;
                m_sig[el % SB] = 1'b1;
            end
            if (act && av) begin
                if (aw) m_wr[al] = 1'b1;
                else    m_rd[al] = 1'b1;
            end
        end
    endtask

    task automatic cyc(input int op, input bit av, input bit aw, input int al,
                       input bit ev, input int el, input bit sv, input int sl,
                       input string tag);
        cmd_op = 2'(op); acc_valid = av; acc_write = aw; acc_line = IW'(al);
        evict_valid = ev; evict_line = IW'(el); snoop_valid = sv; snoop_line = IW'(sl);
        model_step(op, av, aw, al, ev, el, sv, sl);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        cmd_op = 0; acc_valid = 0; acc_write = 0; acc_line = 0;
        evict_valid = 0; evict_line = 0; snoop_valid = 0; snoop_line = 0;
        m_rd = '0; m_wr = '0; m_sig = '0; m_flush = '0; m_pub = '0;
        m_depth = 0; m_cause = 0; m_done = 0; m_ab = 0; m_cm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1");
        idle("R1");

        // R4: activity while idle leaves no trace
        cyc(3, 1, 1, 2, 1, 2, 1, 2, "R4");
        cyc(2, 1, 0, 5, 0, 0, 0, 0, "R3");

        // R2 nesting up to the ceiling, then overflow
        for (int k = 0; k < MD; k++) cyc(1, 1, 0, k, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R11: cause holds while idle, clears on the next outer open
        idle("R11"); idle("R11"); idle("R11");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R11");

        // R3: inner close, then outermost close commits
        cyc(1, 1, 1, 3, 0, 0, 0, 0, "R3");
        cyc(0, 1, 0, 5, 0, 0, 0, 0, "R4");
        cyc(2, 0, 0, 0, 0, 0, 0, 0, "R3");
        cyc(2, 0, 0, 0, 0, 0, 0, 0, "R3");
        idle("R3");

        // R5: evicting a written line
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R5");
        cyc(0, 1, 1, 2, 0, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 1, 2, 0, 0, "R5");
        idle("R9");

        // R6 then R7: read line 6 evicted, snoop on 10 hits slot 2
        cyc(1, 1, 0, 6, 0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 1, 6, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 1, 9, "R7");
        cyc(0, 0, 0, 0, 0, 0, 1, 10, "R7");
        // R6: eviction and read of the same line in one cycle
        cyc(1, 1, 0, 8, 0, 0, 0, 0, "R6");
        cyc(0, 1, 0, 8, 1, 8, 0, 0, "R6");
        cyc(0, 1, 1, 9, 0, 0, 1, 11, "R7");

        // R8 with R9 flush contents
        cyc(1, 1, 1, 1, 0, 0, 0, 0, "R8");
        cyc(0, 1, 1, 14, 0, 0, 0, 0, "R8");
        cyc(3, 0, 0, 0, 0, 0, 0, 0, "R8");
        idle("R9");

        // R10: priorities
        cyc(1, 1, 1, 4, 0, 0, 0, 0, "R10");
        cyc(0, 1, 0, 7, 0, 0, 0, 0, "R10");
        cyc(3, 0, 0, 0, 1, 4, 1, 7, "R10");
        cyc(1, 1, 1, 4, 0, 0, 0, 0, "R10");
        cyc(0, 1, 0, 7, 0, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 1, 4, 1, 7, "R10");
        cyc(1, 1, 1, 4, 0, 0, 0, 0, "R10");
        cyc(2, 0, 0, 0, 1, 4, 0, 0, "R10");
        idle("R10");

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int r, op;
            r  = int'($urandom % 100);
            op = (r < 12) ? 1 : (r < 20) ? 2 : (r < 22) ? 3 : 0;
            cyc(op,
                ($urandom % 100) < 50, $urandom % 2, int'($urandom % NL),
                ($urandom % 100) < 8,  int'($urandom % NL),
                ($urandom % 100) < 6,  int'($urandom % NL),
                "R4");
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule